// File: doc/BRIEF.md
# Post-Shutdown AGC Boost Controller

This block steers the two current sources of an AGC charge pump: an attack source that pushes charge and a decay source that pulls it. While the receiver is held in shutdown, neither source runs, so the AGC capacitor floats and keeps its voltage. When shutdown is released, both sources are scaled up by 45 for a fixed number of reference cycles. This recharges the capacitor quickly after any droop. Because the window is a fixed cycle count, its length in time scales inversely with the reference frequency.

The shutdown input is asynchronous to the reference clock and passes through a two-stage synchronizer. The attack request comes from the level detector in the reference clock domain. At any moment the block selects exactly one current direction: attack when requested, decay otherwise. Each source carries a current code in decay-current units. Attack is 10 and decay is 1, which gives a 10:1 ratio, and both codes are multiplied by 45 while the boost window is open.

Top module: `agc_boost_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and on the first cycle after it, `push_en_o`, `pull_en_o` and `boost_o` are 0, and both level codes are 0.
- R2: From the third rising edge after `shut_i` goes high, `push_en_o` and `pull_en_o` are both 0 and both level codes are 0. This holds for as long as `shut_i` stays high.
- R3: On the third rising edge after `shut_i` falls, `boost_o` rises and the selected current source is enabled. On the second edge after the fall, `boost_o` is still 0.
- R4: Once raised, `boost_o` stays high for exactly BOOST_CYCLES reference cycles (default 65 400) and then returns to 0. Shutdown must stay low for that whole time.
- R5: While shutdown is low, `attack_req_i` = 1 gives `push_en_o` = 1 and `pull_en_o` = 0 one edge later, and `attack_req_i` = 0 gives the opposite. The two enables are never 1 together.
- R6: Raising `shut_i` during a boost window clears `boost_o` on the third edge after the rise. A later release opens a fresh window of full length.
- R7: `push_lvl_o` is 10 when push is enabled without boost, 450 with boost, and 0 when push is disabled. `pull_lvl_o` is 1, 45 and 0 under the same three conditions. Both codes are 9 bits wide.
- R8: If `shut_i` is already low when reset is released, a boost window opens on the third edge after release, as for a normal release of shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shut_i | input | 1 | Shutdown level, active high, asynchronous |
| attack_req_i | input | 1 | 1 selects the attack (push) source, 0 selects the decay (pull) source |
| push_en_o | output | 1 | Enable for the attack current source |
| pull_en_o | output | 1 | Enable for the decay current source |
| boost_o | output | 1 | High while the ×45 boost window is open |
| push_lvl_o | output | 9 | Attack current code in decay-current units |
| pull_lvl_o | output | 9 | Decay current code in decay-current units |

## Verification
The assertions assume that `attack_req_i` is synchronous to the reference clock. They also assume that `shut_i` is stable for at least one clock cycle before the synchronizer samples it. The bench meets both assumptions by changing every input one time unit after a rising edge, never at the edge itself. The countdown assertion assumes that no new release edge arrives while a window is still counting down. The stimulus therefore reasserts shutdown before it releases again. The bench does not let a glitch on the shutdown input reach the synchronizer.

// File: rtl/agc_boost_pkg.sv
// Package: shared constants for the AGC boost controller.
// Assumes that current codes are expressed in units of the decay current.
package agc_boost_pkg;
    localparam int unsigned DEF_BOOST_CYCLES = 65400;
    localparam int unsigned DEF_PUSH_UNITS   = 10;
    localparam int unsigned DEF_PULL_UNITS   = 1;
    localparam int unsigned DEF_BOOST_MULT   = 45;

    // Width that can hold the given value.
    function automatic int unsigned width_of(input int unsigned value);
        return (value < 2) ? 1 : $clog2(value + 1);
    endfunction
endpackage

// File: rtl/shut_sync.sv
// Module: shut_sync
// Brings the asynchronous shutdown level into the clock domain through two
// flops and flags the cycle on which the synchronized level falls.
// Assumes: during reset the shutdown is treated as asserted, so a low input
// at reset exit produces a release edge.
module shut_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic shut_i,
    output logic shut_s_o,
    output logic rel_o
);
    logic meta_q, sync_q, prev_q;

    // Two-flop synchronizer plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= shut_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign shut_s_o = sync_q;
    assign rel_o    = prev_q & ~sync_q;

    // R3: a release pulse lasts one cycle only.
    a_r3_release_single: assert property (@(posedge clk) disable iff (!rst_n)
        rel_o |=> !rel_o);
endmodule

// File: rtl/boost_timer.sv
// Module: boost_timer
// One-shot down-counter. A release pulse loads it with BOOST_CYCLES, and
// boost is high while the count is nonzero. Synchronized shutdown clears it.
// Assumes: release and shutdown are mutually exclusive in any one cycle.
module boost_timer #(
    parameter int unsigned BOOST_CYCLES = agc_boost_pkg::DEF_BOOST_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shut_s_i,
    input  logic rel_i,
    output logic boost_o
);
    localparam int unsigned CNT_W = agc_boost_pkg::width_of(BOOST_CYCLES);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BOOST_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load on release, clear on shutdown, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (shut_s_i)
            cnt_q <= '0;
        else if (rel_i)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign boost_o = (cnt_q != '0);

    // R3: a release loads the full window.
    a_r3_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i && !shut_s_i |=> cnt_q == LOAD);
    // R6: synchronized shutdown aborts the window.
    a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
        shut_s_i |=> !boost_o);
    // R4: with no interruption the count falls by exactly one.
    a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && !shut_s_i && !rel_i |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/pump_steer.sv
// Module: pump_steer
// Registers the push and pull enables from the attack request, gated by the
// synchronized shutdown, and forms the current codes with the boost scale.
// Assumes: attack request is synchronous to clk.
module pump_steer #(
    parameter int unsigned PUSH_UNITS = agc_boost_pkg::DEF_PUSH_UNITS,
    parameter int unsigned PULL_UNITS = agc_boost_pkg::DEF_PULL_UNITS,
    parameter int unsigned BOOST_MULT = agc_boost_pkg::DEF_BOOST_MULT,
    parameter int unsigned LVL_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shut_s_i,
    input  logic             attack_req_i,
    input  logic             boost_i,
    output logic             push_en_o,
    output logic             pull_en_o,
    output logic [LVL_W-1:0] push_lvl_o,
    output logic [LVL_W-1:0] pull_lvl_o
);
    localparam logic [LVL_W-1:0] PUSH_NORM  = LVL_W'(PUSH_UNITS);
    localparam logic [LVL_W-1:0] PUSH_BOOST = LVL_W'(PUSH_UNITS * BOOST_MULT);
    localparam logic [LVL_W-1:0] PULL_NORM  = LVL_W'(PULL_UNITS);
    localparam logic [LVL_W-1:0] PULL_BOOST = LVL_W'(PULL_UNITS * BOOST_MULT);

    logic push_q, pull_q;

    // Choose exactly one direction while awake, none while in shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_q <= 1'b0;
            pull_q <= 1'b0;
        end else begin
            push_q <= ~shut_s_i &  attack_req_i;
            pull_q <= ~shut_s_i & ~attack_req_i;
        end
    end

    // Current codes: zero when off, boosted scale inside the window.
    always_comb begin
        push_lvl_o = '0;
        pull_lvl_o = '0;
        if (push_q) push_lvl_o = boost_i ? PUSH_BOOST : PUSH_NORM;
        if (pull_q) pull_lvl_o = boost_i ? PULL_BOOST : PULL_NORM;
    end

    assign push_en_o = push_q;
    assign pull_en_o = pull_q;

    // R5: never both directions at once.
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_en_o, pull_en_o}));
    // R5: an attack request while awake selects push on the next edge.
    a_r5_attack_push: assert property (@(posedge clk) disable iff (!rst_n)
        !shut_s_i && attack_req_i |=> push_en_o);
    // R2: shutdown freezes both sources.
    a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        shut_s_i |=> !push_en_o && !pull_en_o);
endmodule

// File: rtl/agc_boost_ctrl.sv
// Module: agc_boost_ctrl (top)
// Gates the AGC charge-pump sources during shutdown and opens a fixed-length
// ×BOOST_MULT window after each release of shutdown.
// Assumes: shut_i may be asynchronous and attack_req_i is synchronous to clk.
module agc_boost_ctrl #(
    parameter int unsigned BOOST_CYCLES = agc_boost_pkg::DEF_BOOST_CYCLES,
    parameter int unsigned PUSH_UNITS   = agc_boost_pkg::DEF_PUSH_UNITS,
    parameter int unsigned PULL_UNITS   = agc_boost_pkg::DEF_PULL_UNITS,
    parameter int unsigned BOOST_MULT   = agc_boost_pkg::DEF_BOOST_MULT,
    parameter int unsigned LVL_W        = agc_boost_pkg::width_of(PUSH_UNITS * BOOST_MULT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shut_i,
    input  logic             attack_req_i,
    output logic             push_en_o,
    output logic             pull_en_o,
    output logic             boost_o,
    output logic [LVL_W-1:0] push_lvl_o,
    output logic [LVL_W-1:0] pull_lvl_o
);
    logic shut_s, rel;

    shut_sync i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .shut_i   (shut_i),
        .shut_s_o (shut_s),
        .rel_o    (rel)
    );

    boost_timer #(.BOOST_CYCLES(BOOST_CYCLES)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .shut_s_i (shut_s),
        .rel_i    (rel),
        .boost_o  (boost_o)
    );

    pump_steer #(
        .PUSH_UNITS (PUSH_UNITS),
        .PULL_UNITS (PULL_UNITS),
        .BOOST_MULT (BOOST_MULT),
        .LVL_W      (LVL_W)
    ) i_steer (
        .clk          (clk),
        .rst_n        (rst_n),
        .shut_s_i     (shut_s),
        .attack_req_i (attack_req_i),
        .boost_i      (boost_o),
        .push_en_o    (push_en_o),
        .pull_en_o    (pull_en_o),
        .push_lvl_o   (push_lvl_o),
        .pull_lvl_o   (pull_lvl_o)
    );

    // R7: boost never coexists with zero current while a source is enabled.
    a_r7_boost_level: assert property (@(posedge clk) disable iff (!rst_n)
        boost_o && push_en_o |-> push_lvl_o > LVL_W'(PUSH_UNITS));
endmodule

// File: tb/test_agc_boost_ctrl.sv
module test_agc_boost_ctrl;
    localparam int unsigned N = 65400;
    localparam int unsigned WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shut_i = 1'b1;
    logic attack_req_i = 1'b0;
    logic push_en_o, pull_en_o, boost_o;
    logic [8:0] push_lvl_o, pull_lvl_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    agc_boost_ctrl i_agc_boost_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .shut_i       (shut_i),
        .attack_req_i (attack_req_i),
        .push_en_o    (push_en_o),
        .pull_en_o    (pull_en_o),
        .boost_o      (boost_o),
        .push_lvl_o   (push_lvl_o),
        .pull_lvl_o   (pull_lvl_o)
    );

    // Row layout: shut, att, push, pull, boost, push_lvl[9], pull_lvl[9].
    localparam logic [22:0] TBL [5] = '{
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 9'd450, 9'd0 },
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'd0,   9'd45},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 9'd450, 9'd0 },
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0,   9'd0 },
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   9'd0 }
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with shutdown low and attack requested.
        shut_i = 1'b0;
        attack_req_i = 1'b1;
        step(3);
        chk("R1 push_en", push_en_o, 0);
        chk("R1 pull_en", pull_en_o, 0);
        chk("R1 boost", boost_o, 0);
        chk("R1 push_lvl", push_lvl_o, 0);

        // R8: release reset while shutdown is already low.
        rst_n = 1'b1;
        step(1);
        chk("R1 first cycle boost", boost_o, 0);
        step(1);
        chk("R8 boost not yet", boost_o, 0);
        step(1);
        chk("R8 boost at third edge", boost_o, 1);
        chk("R8 push_lvl boosted", push_lvl_o, 450);

        // Back into shutdown before the table walk.
        shut_i = 1'b1;
        step(2);
        chk("R6 boost before clear", boost_o, 1);
        step(1);
        chk("R6 abort clears boost", boost_o, 0);
        chk("R2 push off", push_en_o, 0);
        step(2);

        // Table walk: the first row releases shutdown.
        for (int i = 0; i < 5; i++) begin
            shut_i = TBL[i][22];
            attack_req_i = TBL[i][21];
            step(3);
            chk("R5 push_en", push_en_o, TBL[i][20]);
            chk("R5 pull_en", pull_en_o, TBL[i][19]);
            chk("R3 boost", boost_o, TBL[i][18]);
            chk("R7 push_lvl", push_lvl_o, TBL[i][17:9]);
            chk("R7 pull_lvl", pull_lvl_o, TBL[i][8:0]);
            chk("R2 R5 exclusive", push_en_o & pull_en_o, 0);
        end

        // R5: an attack request takes effect one edge later.
        shut_i = 1'b0;
        attack_req_i = 1'b0;
        step(3);
        chk("R3 boost on release", boost_o, 1);
        attack_req_i = 1'b1;
        step(1);
        chk("R5 push after one edge", push_en_o, 1);
        chk("R5 pull dropped", pull_en_o, 0);

        // R6: abort, then a fresh release opens a full window (R4).
        shut_i = 1'b1;
        step(3);
        chk("R6 abort", boost_o, 0);
        chk("R2 pull off", pull_en_o, 0);
        step(5);
        chk("R2 still frozen", push_lvl_o, 0);
        attack_req_i = 1'b0;
        shut_i = 1'b0;
        step(3);
        chk("R6 reload", boost_o, 1);
        step(N - 1);
        chk("R4 last cycle of window", boost_o, 1);
        chk("R7 pull boosted", pull_lvl_o, 45);
        step(1);
        chk("R4 window ended", boost_o, 0);
        chk("R7 pull normal", pull_lvl_o, 1);
        attack_req_i = 1'b1;
        step(1);
        chk("R7 push normal", push_lvl_o, 10);

        // R2: shutdown raised with no window open.
        shut_i = 1'b1;
        step(2);
        chk("R2 not yet frozen", push_en_o, 1);
        step(1);
        chk("R2 frozen", push_en_o, 0);
        chk("R2 levels zero", push_lvl_o + pull_lvl_o, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule